// File: doc/BRIEF.md
# Buffered Program Sequencer

This block sits behind a command interface that has already latched each bus write into an address/data pair. It follows the multi-cycle buffered program command. A setup code of 0xE8 opens the sequence. The next write carries a word count N. Exactly N+1 data writes follow, and each one lands in a 16-word staging buffer. The sequence closes with the confirm code 0xD0. Only after the confirm does the block offer the filled buffer to the array-programming engine, together with the first data address and N.

There are two staging buffers. They are filled in turn and drained in the same order, so the host can load one buffer while the engine programs the other. A status byte tells the host whether a buffer is free. It also holds two sticky error flags: one for a count or address outside the allowed range, and one for a broken sequence. An abort of either kind returns the buffer to the free pool.

Command writes use a valid/ready stream. The block lowers `cmd_ready` only while it waits for the count and no buffer is free, so the count write stalls until the engine releases one. The engine side is also a handshake. `prog_valid`, `prog_addr` and `prog_count` hold steady until the engine raises `prog_done`. A buffer is released on a cycle where both `prog_valid` and `prog_done` are high. While `prog_valid` is high, the engine reads words through `prog_idx`/`prog_word`.

Top module: `bufwr_seq`

## Requirements
- R1: After reset, `status` reads 0x80, `prog_valid` is 0 and `cmd_ready` is 1.
- R2: A write sequence of 0xE8, then N (0..15), then N+1 data writes, then 0xD0 (codes taken from `cmd_data[7:0]`) makes `prog_valid` rise after the confirm is accepted. `prog_addr` then equals the address of the first data write and `prog_count` equals N. `prog_word` at index i returns the i-th data word.
- R3: `prog_valid` stays 0 while data words are being collected, before the confirm is accepted.
- R4: Any code other than 0xD0 in the confirm position aborts the sequence. It sets status bit 4, frees the buffer (bit 7 stays 1) and raises no program request.
- R5: A count above 15 sets status bit 5, claims no buffer, and returns the block to waiting for a setup code.
- R6: A data write whose address lies outside the 16-word aligned window of the first data address sets status bit 5 and discards the buffer.
- R7: Status bits 5 and 4 stay set until the code 0x50 is written while the block waits for a setup code; that write clears both.
- R8: Two buffers are filled alternately. A second sequence can complete while the first is still pending. Status bit 7 is 0 when both buffers are full. Buffers are offered to the engine in the order they were confirmed.
- R9: While the count write is pending and no buffer is free, `cmd_ready` is 0. The count write is accepted once `prog_done` frees a buffer.
- R10: `prog_valid`, `prog_addr` and `prog_count` hold steady until a cycle with `prog_valid` and `prog_done` both high. That cycle frees the buffer.
- R11: While waiting for a setup code, codes other than 0xE8 and 0x50 have no effect on status or on the program request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write present |
| cmd_ready | output | 1 | Command write accepted this cycle when high with cmd_valid |
| cmd_addr | input | 22 | Latched write address |
| cmd_data | input | 16 | Latched write data; codes in bits 7:0 |
| status | output | 8 | Bit 7 buffer free, bit 5 range error, bit 4 sequence error, others 0 |
| prog_valid | output | 1 | A confirmed buffer awaits programming |
| prog_done | input | 1 | Engine finished the offered buffer |
| prog_addr | output | 22 | First data address of the offered buffer |
| prog_count | output | 4 | Word count minus one of the offered buffer |
| prog_idx | input | 4 | Word index read by the engine |
| prog_word | output | 16 | Buffer word at prog_idx |

## Verification
The bench covers the count boundaries 0 and 15 and a count of 16. A design that got these wrong would lose the last word, or would accept an oversized count and claim a buffer. A non-confirm code in the confirm slot must abort cleanly and keep the buffer free; an off-by-one in the word counter would instead take a data word as the confirm or the other way round. A data address that jumps to the next 16-word window must raise the range flag. The ping-pong run fills both buffers, stalls a count write against a full pool, and checks that drain order matches fill order. A design with a swapped pointer or a ready that ignores free space would hand out the wrong buffer or overwrite one that is still pending.

// File: rtl/bufwr_pkg.sv
package bufwr_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_COUNT, SQ_DATA, SQ_CONFIRM} seq_state_t;
  typedef enum logic [1:0] {SLOT_FREE, SLOT_FILL, SLOT_FULL} slot_state_t;
  localparam logic [7:0] OP_SETUP   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
endpackage

// File: rtl/bufwr_ring.sv
module bufwr_ring
  import bufwr_pkg::*;
#(
  parameter int NBUF = 2,
  localparam int PW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim,
  input  logic          commit,
  input  logic          discard,
  input  logic          drain_done,
  output logic          fill_free,
  output logic [PW-1:0] fill_ptr,
  output logic [PW-1:0] drain_ptr,
  output logic          drain_full
);
  slot_state_t slot [NBUF];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(NBUF - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[g] <= SLOT_FREE;
      else if (drain_done && drain_ptr == PW'(g)) slot[g] <= SLOT_FREE;
      else if (commit && fill_ptr == PW'(g)) slot[g] <= SLOT_FULL;
      else if (discard && fill_ptr == PW'(g)) slot[g] <= SLOT_FREE;
      else if (claim && fill_ptr == PW'(g)) slot[g] <= SLOT_FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_ptr  <= '0;
      drain_ptr <= '0;
    end else begin
      if (commit) fill_ptr <= step(fill_ptr);
      if (drain_done) drain_ptr <= step(drain_ptr);
    end
  end

  assign fill_free  = (slot[fill_ptr] == SLOT_FREE);
  assign drain_full = (slot[drain_ptr] == SLOT_FULL);

  assert_claim_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> fill_free);
  assert_discard_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> fill_free);
  assert_commit_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> fill_ptr != $past(fill_ptr));
  assert_done_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> drain_ptr != $past(drain_ptr));
endmodule

// File: rtl/bufwr_bank.sv
module bufwr_bank #(
  parameter int NBUF  = 2,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int AW    = 22,
  localparam int PW = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int OW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_buf,
  input  logic [OW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          meta_en,
  input  logic [AW-1:0] meta_addr,
  input  logic [OW-1:0] meta_cnt,
  input  logic [PW-1:0] rd_buf,
  input  logic [OW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic [OW-1:0] rd_cnt
);
  logic [DW-1:0] mem   [NBUF][DEPTH];
  logic [AW-1:0] m_adr [NBUF];
  logic [OW-1:0] m_cnt [NBUF];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_buf][wr_idx] <= wr_data;
    if (meta_en) begin
      m_adr[wr_buf] <= meta_addr;
      m_cnt[wr_buf] <= meta_cnt;
    end
  end

  assign rd_data = mem[rd_buf][rd_idx];
  assign rd_addr = m_adr[rd_buf];
  assign rd_cnt  = m_cnt[rd_buf];
endmodule

// File: rtl/bufwr_fsm.sv
module bufwr_fsm
  import bufwr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int AW    = 22,
  localparam int OW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          fill_free,
  output logic          claim,
  output logic          commit,
  output logic          discard,
  output logic          wr_en,
  output logic [OW-1:0] wr_idx,
  output logic [AW-1:0] meta_addr,
  output logic [OW-1:0] meta_cnt,
  output logic          err_rng,
  output logic          err_seq
);
  seq_state_t       st;
  logic [OW-1:0]    idx, cnt;
  logic [AW-OW-1:0] win;
  logic [AW-1:0]    saddr;
  logic             acc, count_ok, in_win;
  logic [7:0]       code;

  assign code      = cmd_data[7:0];
  assign cmd_ready = (st == SQ_COUNT) ? fill_free : 1'b1;
  assign acc       = cmd_valid && cmd_ready;
  assign count_ok  = (cmd_data < DW'(DEPTH));
  assign in_win    = (idx == '0) || (cmd_addr[AW-1:OW] == win);

  always_comb begin
    claim   = acc && (st == SQ_COUNT) && count_ok;
    commit  = acc && (st == SQ_CONFIRM) && (code == OP_CONFIRM);
    discard = acc && (((st == SQ_DATA) && !in_win) ||
                      ((st == SQ_CONFIRM) && (code != OP_CONFIRM)));
    wr_en   = acc && (st == SQ_DATA) && in_win;
  end

  assign wr_idx    = idx;
  assign meta_addr = saddr;
  assign meta_cnt  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      idx     <= '0;
      cnt     <= '0;
      win     <= '0;
      saddr   <= '0;
      err_rng <= 1'b0;
      err_seq <= 1'b0;
    end else if (acc) begin
      unique case (st)
        SQ_IDLE: begin
          if (code == OP_SETUP) st <= SQ_COUNT;
          else if (code == OP_CLEAR) begin
            err_rng <= 1'b0;
            err_seq <= 1'b0;
          end
        end
        SQ_COUNT: begin
          if (count_ok) begin
            cnt <= cmd_data[OW-1:0];
            idx <= '0;
            st  <= SQ_DATA;
          end else begin
            err_rng <= 1'b1;
            st      <= SQ_IDLE;
          end
        end
        SQ_DATA: begin
          if (!in_win) begin
            err_rng <= 1'b1;
            st      <= SQ_IDLE;
          end else begin
            if (idx == '0) begin
              win   <= cmd_addr[AW-1:OW];
              saddr <= cmd_addr;
            end
            if (idx == cnt) st <= SQ_CONFIRM;
            else idx <= idx + 1'b1;
          end
        end
        SQ_CONFIRM: begin
          if (code != OP_CONFIRM) err_seq <= 1'b1;
          st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_DATA) |-> (idx <= cnt));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seq && !(acc && st == SQ_IDLE && code == OP_CLEAR)) |=> err_seq);
  assert_rng_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rng && !(acc && st == SQ_IDLE && code == OP_CLEAR)) |=> err_rng);
endmodule

// File: rtl/bufwr_seq.sv
module bufwr_seq #(
  parameter int NBUF  = 2,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int AW    = 22,
  localparam int PW = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int OW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic [7:0]    status,
  output logic          prog_valid,
  input  logic          prog_done,
  output logic [AW-1:0] prog_addr,
  output logic [OW-1:0] prog_count,
  input  logic [OW-1:0] prog_idx,
  output logic [DW-1:0] prog_word
);
  logic          claim, commit, discard, wr_en, fill_free, drain_full;
  logic [OW-1:0] wr_idx, meta_cnt;
  logic [AW-1:0] meta_addr;
  logic [PW-1:0] fill_ptr, drain_ptr;
  logic          err_rng, err_seq, drain_done;

  bufwr_fsm #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .fill_free(fill_free),
    .claim(claim), .commit(commit), .discard(discard), .wr_en(wr_en),
    .wr_idx(wr_idx), .meta_addr(meta_addr), .meta_cnt(meta_cnt),
    .err_rng(err_rng), .err_seq(err_seq)
  );

  assign drain_done = prog_valid && prog_done;

  bufwr_ring #(.NBUF(NBUF)) u_ring (
    .clk(clk), .rst_n(rst_n), .claim(claim), .commit(commit),
    .discard(discard), .drain_done(drain_done), .fill_free(fill_free),
    .fill_ptr(fill_ptr), .drain_ptr(drain_ptr), .drain_full(drain_full)
  );

  bufwr_bank #(.NBUF(NBUF), .DEPTH(DEPTH), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .wr_en(wr_en), .wr_buf(fill_ptr), .wr_idx(wr_idx),
    .wr_data(cmd_data), .meta_en(commit), .meta_addr(meta_addr),
    .meta_cnt(meta_cnt), .rd_buf(drain_ptr), .rd_idx(prog_idx),
    .rd_data(prog_word), .rd_addr(prog_addr), .rd_cnt(prog_count)
  );

  assign prog_valid = drain_full;
  assign status     = {fill_free, 1'b0, err_rng, err_seq, 4'b0000};

  assert_prog_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && !prog_done) |=> (prog_valid && $stable(prog_addr) && $stable(prog_count)));
  assert_no_early_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid) |-> $past(commit));
endmodule

// File: tb/bufwr_seq_tb.sv
module bufwr_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_ready;
  logic [21:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [7:0]  status;
  logic        prog_valid, prog_done = 0;
  logic [21:0] prog_addr;
  logic [3:0]  prog_count, prog_idx = '0;
  logic [15:0] prog_word;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  bufwr_seq u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      errors++;
      $display("FAIL watchdog act %0d exp <20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic load(input logic [21:0] a, input int n, input logic [15:0] base);
    send(a, 16'h00E8);
    send(a, 16'(n));
    for (int i = 0; i <= n; i++) send(a + 22'(i), base + 16'(i));
  endtask

  task automatic drain_chk(input string tag, input logic [21:0] a, input int n, input logic [15:0] base);
    chk({tag, " valid"}, 32'(prog_valid), 32'd1);
    chk({tag, " addr"}, 32'(prog_addr), 32'(a));
    chk({tag, " count"}, 32'(prog_count), 32'(n));
    for (int i = 0; i <= n; i++) begin
      prog_idx = 4'(i);
      #1;
      chk({tag, " word"}, 32'(prog_word), 32'(base + 16'(i)));
    end
    prog_done = 1;
    @(posedge clk);
    @(negedge clk);
    prog_done = 0;
  endtask

  task automatic t_reset;
    chk("R1 status", 32'(status), 32'h80);
    chk("R1 prog_valid", 32'(prog_valid), 0);
    chk("R1 cmd_ready", 32'(cmd_ready), 1);
  endtask

  task automatic t_single;
    load(22'h001004, 3, 16'hA000);
    chk("R3 no early request", 32'(prog_valid), 0);
    send(22'h001004, 16'h00D0);
    drain_chk("R2 single", 22'h001004, 3, 16'hA000);
    chk("R2 status after drain", 32'(status), 32'h80);
  endtask

  task automatic t_edges;
    load(22'h00200F, 0, 16'hB000);
    send(22'h00200F, 16'h00D0);
    drain_chk("R2 one word", 22'h00200F, 0, 16'hB000);
    load(22'h003000, 15, 16'hC000);
    chk("R3 no request before confirm", 32'(prog_valid), 0);
    send(22'h003000, 16'h00D0);
    drain_chk("R2 sixteen words", 22'h003000, 15, 16'hC000);
  endtask

  task automatic t_abort;
    load(22'h004000, 1, 16'hD000);
    send(22'h004000, 16'h00FF);
    chk("R4 abort status", 32'(status), 32'h90);
    chk("R4 no request", 32'(prog_valid), 0);
    send(22'h0, 16'h0050);
    chk("R7 clear", 32'(status), 32'h80);
  endtask

  task automatic t_range;
    send(22'h005000, 16'h00E8);
    send(22'h005000, 16'd16);
    chk("R5 count error", 32'(status), 32'hA0);
    send(22'h005000, 16'h00D0);
    chk("R5 no request", 32'(prog_valid), 0);
    send(22'h005000, 16'h00E8);
    send(22'h005000, 16'd3);
    send(22'h001005, 16'h1111);
    send(22'h001010, 16'h2222);
    chk("R6 window error", 32'(status), 32'hA0);
    send(22'h001011, 16'h00D0);
    chk("R6 no request", 32'(prog_valid), 0);
    send(22'h0, 16'h0050);
    chk("R7 clear range", 32'(status), 32'h80);
  endtask

  task automatic t_ignore;
    send(22'h0, 16'h00FF);
    send(22'h0, 16'h00D0);
    chk("R11 status unchanged", 32'(status), 32'h80);
    chk("R11 no request", 32'(prog_valid), 0);
    load(22'h007000, 1, 16'h7000);
    send(22'h007000, 16'h00D0);
    drain_chk("R11 sequence after noise", 22'h007000, 1, 16'h7000);
  endtask

  task automatic t_pingpong;
    load(22'h004000, 1, 16'h4000);
    send(22'h004000, 16'h00D0);
    load(22'h005000, 2, 16'h5000);
    send(22'h005000, 16'h00D0);
    chk("R8 both full", 32'(status), 32'h00);
    send(22'h006000, 16'h00E8);
    @(negedge clk);
    cmd_valid = 1; cmd_addr = 22'h006000; cmd_data = 16'd0;
    for (int k = 0; k < 3; k++) begin
      chk("R9 count stalls", 32'(cmd_ready), 0);
      chk("R10 held valid", 32'(prog_valid), 1);
      chk("R10 held addr", 32'(prog_addr), 32'h004000);
      @(negedge clk);
    end
    drain_chk("R8 first drained", 22'h004000, 1, 16'h4000);
    chk("R9 ready after free", 32'(cmd_ready), 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    send(22'h006000, 16'h6000);
    send(22'h006000, 16'h00D0);
    chk("R8 full again", 32'(status), 32'h00);
    drain_chk("R8 second drained", 22'h005000, 2, 16'h5000);
    drain_chk("R8 third drained", 22'h006000, 0, 16'h6000);
    chk("R8 all free", 32'(status), 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_edges();
    t_abort();
    t_range();
    t_ignore();
    t_pingpong();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule